// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes a stereo audio stream carried on three wires (a bit clock, a word clock that marks the left and right channels, and a serial data line) and turns it into parallel signed left and right samples. The bit and word clocks are synchronous to the system clock but slower than it. Both are brought into the system clock domain through two-flop synchronizers, and every bit-clock edge is detected there. Data is taken on each rising edge of the bit clock, most significant bit first, in two's-complement form.

A three-bit format select chooses the justification and the word length at run time. Left-justified, I2S and right-justified framing are supported, each with 16-bit or 24-bit words. The bit clock may run at 32, 48 or 64 times the word rate. A completed stereo pair is presented on the sample outputs together with a one-cycle valid strobe. A status flag reports half-frames that are too short for the chosen format.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is asserted and until the first stereo pair completes, both sample outputs are zero and the valid strobe is low. The format error flag is low until a half-frame has closed.
- R2: Bits [1:0] of the format select choose the framing: 00 left-justified, 01 I2S, 10 right-justified, 11 left-justified. Bit 2 chooses the word length: 0 for 24 bits, 1 for 16 bits. Code 000 (24-bit left-justified) is therefore the format in force out of reset.
- R3: In left-justified framing, the MSB is the bit taken at the first bit-clock rise after a word clock change. The left word is sent while the word clock is high. Bits after the word-length-th bit of a half-frame are ignored.
- R4: In I2S framing, the MSB is taken at the second bit-clock rise after a word clock change. The left word is sent while the word clock is low.
- R5: In right-justified framing, the last bit before a word clock change is the LSB. Only the final word-length bits of each half-frame are kept, and earlier bits are ignored.
- R6: 16-bit words appear on the 24-bit outputs sign-extended from bit 15.
- R7: When a half-frame holds fewer bits than the word length, the bits received fill the top of the word and the missing low bits are zero.
- R8: Each time a half-frame closes, the format error flag is set to 1 if that half-frame held fewer bits than 24 (I2S framing, either word length) or fewer than the word length (other framings). Otherwise it is set to 0. The flag holds its value between closes.
- R9: The valid strobe is high for exactly one system cycle per stereo pair (a left half-frame followed by a right half-frame). The sample outputs change only in the cycle in which the valid strobe is high.
- R10: Bit clock rates of 32, 48 and 64 times the word rate are all deframed correctly in every format allowed at that rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bckIn | input | 1 | Serial bit clock |
| lrckIn | input | 1 | Word clock (channel select) |
| dataIn | input | 1 | Serial audio data |
| fmtSel | input | 3 | Framing [1:0] and word length [2] select |
| leftSample | output | 24 | Left sample of the last completed pair |
| rightSample | output | 24 | Right sample of the last completed pair |
| sampleValid | output | 1 | One-cycle strobe when a new pair is presented |
| fmtErr | output | 1 | Last closed half-frame was too short for the format |

## Verification
The assertions assume the following about the inputs:
- Each bit-clock phase lasts at least two system cycles.
- The word clock and the data line change only while the bit clock is low, so both are steady in the synchronized domain when a rise is detected.
- The format select is held steady across a stereo pair.

The bench keeps within these limits in three ways:
- It drives each bit-clock phase for three system cycles.
- It changes the word clock and data only on the falling bit-clock phase.
- It switches format only between runs and sends warm-up frames before any frame whose result is checked.

// File: rtl/serial_audio_rx_pkg.sv
package serial_audio_rx_pkg;

  typedef enum logic [1:0] {
    JUST_LEFT  = 2'b00,
    JUST_I2S   = 2'b01,
    JUST_RIGHT = 2'b10,
    JUST_RSVD  = 2'b11
  } justify_e;

  typedef struct packed {
    logic shiftEn;
    logic startHalf;
    logic closeLeft;
    logic closeRight;
    logic publish;
  } rxStrobe_t;

endpackage

// File: rtl/serial_audio_rx_ctrl.sv
module serial_audio_rx_ctrl
  import serial_audio_rx_pkg::*;
#(
  parameter int WORD_MAX      = 24,
  parameter int WORD_SHORT    = 16,
  parameter int MAX_HALF_BITS = 32,
  parameter int CNT_W         = $clog2(MAX_HALF_BITS) + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bckIn,
  input  logic             lrckIn,
  input  logic             dataIn,
  input  logic [2:0]       fmtSel,
  output rxStrobe_t        strb,
  output logic [CNT_W-1:0] bitCnt,
  output logic             dataBit,
  output logic             sampleValid,
  output logic             fmtErr
);

  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] LEN_LONG = CNT_W'(WORD_MAX);
  localparam logic [CNT_W-1:0] LEN_SHRT = CNT_W'(WORD_SHORT);

  logic [1:0] bckSync, lrSync, datSync;
  logic       bckPrev, lrDly, effPrev, armed, leftHeld;
  logic       bitEn, effClk, edgeSeen, closingLeft, isI2s, isRight;
  logic [CNT_W-1:0] wordLen, needLen;
  justify_e   mode;

  assign mode    = justify_e'(fmtSel[1:0]);
  assign isI2s   = (mode == JUST_I2S);
  assign isRight = (mode == JUST_RIGHT);
  assign wordLen = fmtSel[2] ? LEN_SHRT : LEN_LONG;
  assign needLen = isI2s ? LEN_LONG : wordLen;

  assign bitEn    = bckSync[1] & ~bckPrev;
  assign dataBit  = datSync[1];
  // I2S framing is handled by delaying the word clock one bit, which makes it left-justified.
  assign effClk   = isI2s ? lrDly : lrSync[1];
  assign edgeSeen = bitEn && (effClk != effPrev);
  assign closingLeft = (effPrev == !isI2s);

  always_comb begin
    strb            = '0;
    strb.startHalf  = edgeSeen;
    strb.shiftEn    = bitEn && (edgeSeen || isRight || (bitCnt < wordLen));
    strb.closeLeft  = edgeSeen && armed && closingLeft;
    strb.closeRight = edgeSeen && armed && !closingLeft;
    strb.publish    = strb.closeRight && leftHeld;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bckSync <= '0; lrSync <= '0; datSync <= '0;
      bckPrev <= 1'b0; lrDly <= 1'b0; effPrev <= 1'b0;
      armed <= 1'b0; leftHeld <= 1'b0; bitCnt <= '0;
      sampleValid <= 1'b0; fmtErr <= 1'b0;
    end else begin
      bckSync <= {bckSync[0], bckIn};
      lrSync  <= {lrSync[0], lrckIn};
      datSync <= {datSync[0], dataIn};
      bckPrev <= bckSync[1];
      sampleValid <= strb.publish;
      if (bitEn) begin
        lrDly   <= lrSync[1];
        effPrev <= effClk;
        if (edgeSeen) begin
          armed  <= 1'b1;
          bitCnt <= CNT_W'(1);
        end else if (bitCnt != CNT_MAX) begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
      if (strb.closeLeft) leftHeld <= 1'b1;
      else if (strb.closeRight) leftHeld <= 1'b0;
      if (strb.closeLeft || strb.closeRight) fmtErr <= (bitCnt < needLen);
    end
  end

  assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  assert_err_on_close_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(fmtErr) |-> $past(strb.closeLeft || strb.closeRight));

  // Input assumption: the word clock is steady in the synchronized domain at each bit-clock rise.
  assert_lr_setup_R3: assert property (@(posedge clk) disable iff (!rstN)
    bitEn |-> (lrSync[1] == $past(lrSync[1])));

endmodule

// File: rtl/serial_audio_rx_dp.sv
module serial_audio_rx_dp
  import serial_audio_rx_pkg::*;
#(
  parameter int WORD_MAX   = 24,
  parameter int WORD_SHORT = 16,
  parameter int CNT_W      = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  rxStrobe_t           strb,
  input  logic [CNT_W-1:0]    bitCnt,
  input  logic                dataBit,
  input  logic                wordShort,
  output logic [WORD_MAX-1:0] leftSample,
  output logic [WORD_MAX-1:0] rightSample
);

  localparam int EXT_W = WORD_MAX - WORD_SHORT;

  logic [WORD_MAX-1:0] shReg, pendLeft, aligned, closeWord;
  logic [CNT_W-1:0]    wordLen, got, pad;

  assign wordLen = wordShort ? CNT_W'(WORD_SHORT) : CNT_W'(WORD_MAX);
  assign got     = (bitCnt < wordLen) ? bitCnt : wordLen;
  assign pad     = wordLen - got;
  assign aligned = shReg << pad;

  always_comb begin
    if (wordShort)
      closeWord = {{EXT_W{aligned[WORD_SHORT-1]}}, aligned[WORD_SHORT-1:0]};
    else
      closeWord = aligned;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg <= '0; pendLeft <= '0; leftSample <= '0; rightSample <= '0;
    end else begin
      if (strb.shiftEn) begin
        if (strb.startHalf) shReg <= WORD_MAX'(dataBit);
        else                shReg <= {shReg[WORD_MAX-2:0], dataBit};
      end
      if (strb.closeLeft) pendLeft <= closeWord;
      if (strb.publish) begin
        leftSample  <= pendLeft;
        rightSample <= closeWord;
      end
    end
  end

  assert_sign_ext_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.publish && wordShort) |->
      (rightSample[WORD_MAX-1:WORD_SHORT] == {EXT_W{rightSample[WORD_SHORT-1]}}));

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import serial_audio_rx_pkg::*;
#(
  parameter int WORD_MAX      = 24,
  parameter int WORD_SHORT    = 16,
  parameter int MAX_HALF_BITS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bckIn,
  input  logic                lrckIn,
  input  logic                dataIn,
  input  logic [2:0]          fmtSel,
  output logic [WORD_MAX-1:0] leftSample,
  output logic [WORD_MAX-1:0] rightSample,
  output logic                sampleValid,
  output logic                fmtErr
);

  localparam int CNT_W = $clog2(MAX_HALF_BITS) + 2;

  rxStrobe_t        strb;
  logic [CNT_W-1:0] bitCnt;
  logic             dataBit;

  serial_audio_rx_ctrl #(
    .WORD_MAX(WORD_MAX), .WORD_SHORT(WORD_SHORT),
    .MAX_HALF_BITS(MAX_HALF_BITS), .CNT_W(CNT_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .bckIn(bckIn), .lrckIn(lrckIn), .dataIn(dataIn),
    .fmtSel(fmtSel), .strb(strb), .bitCnt(bitCnt), .dataBit(dataBit),
    .sampleValid(sampleValid), .fmtErr(fmtErr)
  );

  serial_audio_rx_dp #(
    .WORD_MAX(WORD_MAX), .WORD_SHORT(WORD_SHORT), .CNT_W(CNT_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .bitCnt(bitCnt), .dataBit(dataBit),
    .wordShort(fmtSel[2]), .leftSample(leftSample), .rightSample(rightSample)
  );

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |-> ($stable(leftSample) && $stable(rightSample)));

endmodule

// File: tb/tb_serial_audio_rx.sv
module tb_serial_audio_rx;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bckIn = 1'b0, lrckIn = 1'b0, dataIn = 1'b0;
  logic [2:0]  fmtSel = 3'b000;
  logic [23:0] leftSample, rightSample;
  logic        sampleValid, fmtErr;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic prevBit = 1'b0;

  logic [23:0] rxL [64];
  logic [23:0] rxR [64];
  int   rxN = 0;
  int   doubleValid = 0;
  int   holdErr = 0;
  logic lastValid = 1'b0;
  logic [23:0] lastL = '0, lastR = '0;

  always #2 clk = ~clk;

  serial_audio_rx dut (
    .clk(clk), .rstN(rstN), .bckIn(bckIn), .lrckIn(lrckIn), .dataIn(dataIn),
    .fmtSel(fmtSel), .leftSample(leftSample), .rightSample(rightSample),
    .sampleValid(sampleValid), .fmtErr(fmtErr)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (sampleValid) begin
        rxL[rxN % 64] = leftSample;
        rxR[rxN % 64] = rightSample;
        rxN++;
        if (lastValid) doubleValid++;
      end else if (leftSample !== lastL || rightSample !== lastR) begin
        holdErr++;
      end
      lastValid = sampleValid;
      lastL = leftSample;
      lastR = rightSample;
    end
  end

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] expect_word(input logic [23:0] w, input int n, input int b);
    logic [23:0] v;
    v = (n == 16) ? {8'h00, w[15:0]} : w;
    if (b < n) v = (v >> (n - b)) << (n - b);
    if (n == 16) v = {{8{v[15]}}, v[15:0]};
    return v;
  endfunction

  task automatic drive_slot(input logic level, input logic bitVal);
    @(negedge clk);
    bckIn = 1'b0; lrckIn = level; dataIn = bitVal;
    repeat (3) @(negedge clk);
    bckIn = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_half(input logic level, input logic [23:0] w, input int n,
                           input int b, input int mode);
    for (int k = 0; k < b; k++) begin
      logic cur;
      if (mode == 2) cur = (k >= b - n) ? w[b - 1 - k] : 1'b1;
      else           cur = (k < n) ? w[n - 1 - k] : 1'b1;
      if (mode == 1) begin
        drive_slot(level, prevBit);
      end else begin
        drive_slot(level, cur);
      end
      prevBit = cur;
    end
  endtask

  task automatic send_frame(input logic [2:0] fmt, input int b,
                            input logic [23:0] l, input logic [23:0] r);
    int mode, n;
    logic leftLevel;
    mode = int'(fmt[1:0]);
    n = fmt[2] ? 16 : 24;
    leftLevel = (mode == 1) ? 1'b0 : 1'b1;
    send_half(leftLevel, l, n, b, mode);
    send_half(!leftLevel, r, n, b, mode);
  endtask

  task automatic run_case(input string tag, input logic [2:0] fmt, input int b,
                          input logic [23:0] l0, input logic [23:0] r0,
                          input logic [23:0] l1, input logic [23:0] r1,
                          input logic expErr);
    int n, snap;
    logic leftLevel;
    n = fmt[2] ? 16 : 24;
    leftLevel = (fmt[1:0] == 2'b01) ? 1'b0 : 1'b1;
    fmtSel = fmt;
    send_frame(fmt, b, 24'h5A5A5A, 24'hA5A5A5);
    send_frame(fmt, b, 24'h3C3C3C, 24'hC3C3C3);
    send_frame(fmt, b, l0, r0);
    snap = rxN;
    send_frame(fmt, b, l1, r1);
    drive_slot(leftLevel, prevBit);
    drive_slot(leftLevel, 1'b0);
    repeat (10) @(negedge clk);
    chk({tag, " R9 pair count"}, 24'(rxN - snap), 24'd2);
    chk({tag, " left0"},  rxL[(rxN - 2) % 64], expect_word(l0, n, b));
    chk({tag, " right0"}, rxR[(rxN - 2) % 64], expect_word(r0, n, b));
    chk({tag, " left1"},  rxL[(rxN - 1) % 64], expect_word(l1, n, b));
    chk({tag, " right1"}, rxR[(rxN - 1) % 64], expect_word(r1, n, b));
    chk({tag, " R8 fmtErr"}, {23'd0, fmtErr}, {23'd0, expErr});
  endtask

  task automatic test_reset();
    repeat (5) @(negedge clk);
    chk("R1 reset left", leftSample, 24'h0);
    chk("R1 reset right", rightSample, 24'h0);
    chk("R1 reset valid", {23'd0, sampleValid}, 24'h0);
    chk("R1 reset fmtErr", {23'd0, fmtErr}, 24'h0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 idle after reset left", leftSample, 24'h0);
  endtask

  task automatic test_left24();
    run_case("R2 R3 R10 LJ24 64fs", 3'b000, 32, 24'h123456, 24'hABCDEF,
             24'h800001, 24'h7FFFFE, 1'b0);
  endtask

  task automatic test_i2s24();
    run_case("R4 R10 I2S24 48fs", 3'b001, 24, 24'hC0FFEE, 24'h135799,
             24'h000001, 24'hFFFFFF, 1'b0);
    run_case("R4 I2S24 64fs", 3'b001, 32, 24'h876543, 24'h2468AC,
             24'hFEDCBA, 24'h000100, 1'b0);
  endtask

  task automatic test_right();
    run_case("R5 R6 R10 RJ16 32fs", 3'b110, 16, 24'h008001, 24'h007FFF,
             24'h00FFFF, 24'h001234, 1'b0);
    run_case("R5 RJ24 64fs", 3'b010, 32, 24'h654321, 24'h800000,
             24'h0F0F0F, 24'hF0F0F0, 1'b0);
  endtask

  task automatic test_left16();
    run_case("R6 LJ16 48fs", 3'b100, 24, 24'h00BEEF, 24'h000042,
             24'h007000, 24'h00C001, 1'b0);
  endtask

  task automatic test_short();
    run_case("R7 R8 LJ24 32fs short", 3'b000, 16, 24'h123456, 24'hFEDCBA,
             24'h89ABCD, 24'h00FF00, 1'b1);
    run_case("R2 R8 reserved code clears", 3'b011, 32, 24'h111111, 24'h222222,
             24'hA0A0A0, 24'h0B0B0B, 1'b0);
    run_case("R8 I2S16 32fs flagged", 3'b101, 16, 24'h00ABCD, 24'h001357,
             24'h008000, 24'h007FFF, 1'b1);
  endtask

  task automatic test_strobe();
    chk("R9 valid never two cycles", 24'(doubleValid), 24'd0);
    chk("R9 outputs held between strobes", 24'(holdErr), 24'd0);
  endtask

  initial begin
    test_reset();
    test_left24();
    test_i2s24();
    test_right();
    test_left16();
    test_short();
    test_strobe();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule